// File: doc/BRIEF.md
# SPI Register Access Front End

This block is the serial slave side of a sensor-style register map with 64 byte-wide locations. While the active-low select is held low, a master clocks in a command byte. The command byte holds a direction flag, a per-transaction address-step flag and a 6-bit register address. One or more data bytes follow. Writes leave the block as single-cycle strobes on a parallel register bus. Reads raise a single-cycle read strobe, collect the byte and shift it back out on the serial output.

A few registers are kept inside the block and never appear on the bus:
- a fixed identity byte;
- three control bytes, which drive power, output-rate and trim-reload controls to the rest of the chip;
- a dummy location whose read pulses a high-pass filter reset.

One control bit switches the port between separate in/out data pins and a single shared pin that turns around after the command byte of a read. All serial inputs are brought into the system clock domain through synchronizers and edge detectors. The serial clock must therefore run well below the system clock: at least 8 system clocks per half period.

Top module: `spi_regif`

## Requirements
- R1: After reset, control bytes 0x20, 0x21 and 0x22 read as 0x07, 0x00 and 0x08. After reset `sdo_oe`, `pwr_on`, `boot_busy`, `bus_we`, `bus_re` and `hpf_rst` are all low.
- R2: Serial bits are sampled on rising `sclk` edges, MSb first. In the command byte, bit 7 is the direction (1 = read, 0 = write), bit 6 is the address-step flag and bits 5:0 are the register address.
- R3: For an address not kept locally, each completed write data byte gives exactly one single-cycle `bus_we` pulse with that byte on `bus_wdata` and its address on `bus_addr`.
- R4: For an address not kept locally, each read data byte gives exactly one single-cycle `bus_re` pulse. `bus_rdata` is taken one clock after the cycle in which `bus_re` is high. The byte appears on `sdo` MSb first, changing after falling `sclk` edges, and is valid at each following rising edge.
- R5: When the step flag is 1, the address advances by one after every data byte and wraps from 0x3F to 0x00. When the step flag is 0, every byte of the transfer uses the same address.
- R6: Address 0x0F reads as 0x3A. Writes to 0x0F have no effect. Neither access raises `bus_we` or `bus_re`.
- R7: Addresses 0x20 to 0x22 are read/write and are mirrored on `ctrl1_o` to `ctrl3_o`. `pwr_on` is high when bits 7:6 of 0x20 are not 00. `odr_sel` equals bits 5:4 of 0x20, coding rates of 40/160/640/2560 Hz as 0 to 3. Writing 0xC7 to 0x20 turns power on.
- R8: Writing 1 to bit 4 of 0x21 starts a trim reload. `boot_busy` is high for BOOT_CYCLES clocks and bit 4 reads 1 meanwhile. At the end of the reload, bit 4 clears itself.
- R9: A read of 0x23 returns 0x00 and gives one single-cycle `hpf_rst` pulse. A write to 0x23 has no effect. Neither access touches the bus.
- R10: With bit 1 of 0x21 at 0 (4-wire), data enters on `sdi`. `sdo_oe` is high while `cs_n` is low and low while `cs_n` is high.
- R11: With bit 1 of 0x21 at 1 (3-wire), data enters on `sdio_i` and `sdi` is ignored. `sdo_oe` rises only after the eighth rising edge of a read command and falls when `cs_n` rises. It stays low for writes.
- R12: Raising `cs_n` mid-byte abandons the transfer. A partial byte causes no strobe, and the next transfer starts with a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in, 4-wire mode |
| sdio_i | input | 1 | Input side of the shared data pin, 3-wire mode |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pad |
| bus_addr | output | 6 | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| bus_we | output | 1 | Register bus write strobe |
| bus_re | output | 1 | Register bus read strobe |
| bus_rdata | input | 8 | Register bus read data |
| ctrl1_o | output | 8 | Control byte at 0x20 |
| ctrl2_o | output | 8 | Control byte at 0x21 |
| ctrl3_o | output | 8 | Control byte at 0x22 |
| pwr_on | output | 1 | Normal operation selected |
| odr_sel | output | 2 | Output data rate code |
| boot_busy | output | 1 | Trim reload in progress |
| hpf_rst | output | 1 | High-pass filter reset pulse |

## Verification
A serial edge reaches the engine three system clocks after the pin changes: two synchronizer stages and one edge-detect register. A write strobe therefore appears about three clocks after the eighth rising edge of its byte. Read data reaches `sdo` about five clocks after the falling edge that starts the byte. `sdo_oe` follows `cs_n` after about three clocks. The bench holds each `sclk` level for 12 clocks and reads `sdo` only on the falling system-clock edge just before it raises `sclk`, so every bit has settled. The bus monitor and the read-data model act on falling system-clock edges. There, a one-cycle `bus_we` or `bus_re` is seen exactly once and is compared against the queue of expected writes.

// File: rtl/spi_regif_pkg.sv
`timescale 1ns/1ps
package spi_regif_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_IDENT = 6'h0F;
  localparam logic [ADDR_W-1:0] A_CTL1  = 6'h20;
  localparam logic [ADDR_W-1:0] A_CTL2  = 6'h21;
  localparam logic [ADDR_W-1:0] A_CTL3  = 6'h22;
  localparam logic [ADDR_W-1:0] A_HPRST = 6'h23;

  localparam logic [DATA_W-1:0] IDENT_VAL = 8'h3A;
  localparam logic [DATA_W-1:0] CTL1_RST  = 8'h07;
  localparam logic [DATA_W-1:0] CTL2_RST  = 8'h00;
  localparam logic [DATA_W-1:0] CTL3_RST  = 8'h08;

  localparam int BOOT_BIT = 4;  // trim reload request in control byte 2
  localparam int SIM_BIT  = 1;  // 1 = shared data pin

  function automatic logic is_local(input logic [ADDR_W-1:0] a);
    return (a == A_IDENT) || (a == A_CTL1) || (a == A_CTL2) ||
           (a == A_CTL3)  || (a == A_HPRST);
  endfunction
endpackage

// File: rtl/spi_regif_sync.sv
`timescale 1ns/1ps
module spi_regif_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_regif_engine.sv
`timescale 1ns/1ps
module spi_regif_engine
  import spi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              din,
  input  logic              sim,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              acc_we,
  output logic              acc_re,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              sclk_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cmd_done, rw, inc, rd_p1;
  logic [DATA_W-2:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] byte_in;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign byte_in = {rx_sr, din};

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b1;
    else     sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt   <= '0;
      cmd_done  <= 1'b0;
      rw        <= 1'b0;
      inc       <= 1'b0;
      rd_p1     <= 1'b0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      sdo       <= 1'b0;
      acc_we    <= 1'b0;
      acc_re    <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      sdo_oe    <= 1'b0;
    end else begin
      acc_we <= 1'b0;
      acc_re <= 1'b0;
      rd_p1  <= acc_re;
      sdo_oe <= !sim || (cmd_done && rw);
      if ((acc_we || acc_re) && inc)
        acc_addr <= acc_addr + ADDR_W'(1);
      if (rd_p1) begin
        sdo   <= rd_data[DATA_W-1];
        tx_sr <= {rd_data[DATA_W-2:0], 1'b0};
      end
      if (rise) begin
        rx_sr   <= byte_in[DATA_W-2:0];
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == CNT_W'(DATA_W-1)) begin
          if (!cmd_done) begin
            cmd_done <= 1'b1;
            rw       <= byte_in[7];
            inc      <= byte_in[6];
            acc_addr <= byte_in[ADDR_W-1:0];
          end else if (!rw) begin
            acc_we    <= 1'b1;
            acc_wdata <= byte_in;
          end
        end
      end
      if (fall && cmd_done && rw) begin
        if (bit_cnt == '0) begin
          acc_re <= 1'b1;
        end else begin
          sdo   <= tx_sr[DATA_W-1];
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> !acc_we);
  assert_no_mix_R4: assert property (@(posedge clk) disable iff (rst)
    !(acc_we && acc_re));
  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdo_oe);
  assert_3w_write_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (sim && !rw) |=> !sdo_oe);
endmodule

// File: rtl/spi_regif_regs.sv
`timescale 1ns/1ps
module spi_regif_regs
  import spi_regif_pkg::*;
#(
  parameter int BOOT_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl1,
  output logic [DATA_W-1:0] ctrl2,
  output logic [DATA_W-1:0] ctrl3,
  output logic              boot_busy,
  output logic              hpf_rst
);
  localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
  localparam logic [DATA_W-1:0] BOOT_MASK = DATA_W'(1) << BOOT_BIT;

  logic [CNT_W-1:0]  boot_cnt;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (addr)
      A_IDENT: rd_mux = IDENT_VAL;
      A_CTL1:  rd_mux = ctrl1;
      A_CTL2:  rd_mux = ctrl2;
      A_CTL3:  rd_mux = ctrl3;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl1     <= CTL1_RST;
      ctrl2     <= CTL2_RST;
      ctrl3     <= CTL3_RST;
      rdata     <= '0;
      hpf_rst   <= 1'b0;
      boot_busy <= 1'b0;
      boot_cnt  <= '0;
    end else begin
      hpf_rst <= rd_en && (addr == A_HPRST);
      if (rd_en) rdata <= rd_mux;
      if (wr_en) begin
        case (addr)
          A_CTL1: ctrl1 <= wdata;
          A_CTL3: ctrl3 <= wdata;
          A_CTL2: begin
            ctrl2 <= wdata | (ctrl2 & BOOT_MASK);
            if (!boot_busy && wdata[BOOT_BIT]) begin
              boot_busy <= 1'b1;
              boot_cnt  <= CNT_W'(BOOT_CYCLES);
            end
          end
          default: ;
        endcase
      end
      if (boot_busy) begin
        if (boot_cnt == CNT_W'(1)) begin
          boot_busy       <= 1'b0;
          ctrl2[BOOT_BIT] <= 1'b0;
        end else begin
          boot_cnt <= boot_cnt - CNT_W'(1);
        end
      end
    end
  end

  assert_boot_bit_R8: assert property (@(posedge clk) disable iff (rst)
    boot_busy |-> ctrl2[BOOT_BIT]);
  assert_boot_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_busy) |-> !ctrl2[BOOT_BIT]);
  assert_hpf_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    hpf_rst |=> !hpf_rst);
endmodule

// File: rtl/spi_regif.sv
`timescale 1ns/1ps
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int BOOT_CYCLES = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sdio_i,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl1_o,
  output logic [DATA_W-1:0] ctrl2_o,
  output logic [DATA_W-1:0] ctrl3_o,
  output logic              pwr_on,
  output logic [1:0]        odr_sel,
  output logic              boot_busy,
  output logic              hpf_rst
);
  logic [3:0]        pins_s;
  logic              cs_act, din_sel;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, loc_rdata, rd_data;
  logic              acc_we, acc_re, hit_local, local_q;

  spi_regif_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sclk, sdi, sdio_i}),
    .q   (pins_s)
  );

  assign cs_act    = ~pins_s[3];
  assign din_sel   = ctrl2_o[SIM_BIT] ? pins_s[0] : pins_s[1];
  assign hit_local = is_local(acc_addr);

  always_ff @(posedge clk) begin
    if (rst)         local_q <= 1'b0;
    else if (acc_re) local_q <= hit_local;
  end

  assign rd_data = local_q ? loc_rdata : bus_rdata;

  spi_regif_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sclk_s    (pins_s[2]),
    .din       (din_sel),
    .sim       (ctrl2_o[SIM_BIT]),
    .rd_data   (rd_data),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_we    (acc_we),
    .acc_re    (acc_re),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  spi_regif_regs #(.BOOT_CYCLES(BOOT_CYCLES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (acc_we && hit_local),
    .rd_en     (acc_re && hit_local),
    .addr      (acc_addr),
    .wdata     (acc_wdata),
    .rdata     (loc_rdata),
    .ctrl1     (ctrl1_o),
    .ctrl2     (ctrl2_o),
    .ctrl3     (ctrl3_o),
    .boot_busy (boot_busy),
    .hpf_rst   (hpf_rst)
  );

  assign bus_addr  = acc_addr;
  assign bus_wdata = acc_wdata;
  assign bus_we    = acc_we && !hit_local;
  assign bus_re    = acc_re && !hit_local;
  assign pwr_on    = |ctrl1_o[7:6];
  assign odr_sel   = ctrl1_o[5:4];

  assert_local_no_bus_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_we || bus_re) |-> !is_local(bus_addr));
endmodule

// File: tb/spi_regif_bench.sv
`timescale 1ns/1ps
module spi_regif_bench;
  localparam int HALF = 12;
  localparam int BOOT = 2000;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, sdio_i = 1'b0;
  logic sdo, sdo_oe, bus_we, bus_re, pwr_on, boot_busy, hpf_rst;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, ctrl1_o, ctrl2_o, ctrl3_o;
  logic [7:0] bus_rdata = 8'h00;
  logic [1:0] odr_sel;

  always #2.5 clk = ~clk;

  spi_regif #(.BOOT_CYCLES(BOOT)) u_spi_regif (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdio_i(sdio_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ctrl1_o(ctrl1_o), .ctrl2_o(ctrl2_o), .ctrl3_o(ctrl3_o),
    .pwr_on(pwr_on), .odr_sel(odr_sel), .boot_busy(boot_busy), .hpf_rst(hpf_rst)
  );

  int vectors = 0, fails = 0, re_cnt = 0, we_cnt = 0, hpf_cnt = 0;
  bit finished = 1'b0;
  bit three_w = 1'b0;
  logic oe_cmd, oe_dat, oe_idle;
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  logic [13:0] exp_q [$];

  function automatic bit own_local(input logic [5:0] a);
    return a == 6'h0F || a == 6'h20 || a == 6'h21 || a == 6'h22 || a == 6'h23;
  endfunction

  function automatic logic [7:0] fwd_val(input logic [5:0] a);
    return {2'b00, a} ^ 8'h5C;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // bus model and write monitor, acting away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_re) begin
        re_cnt++;
        bus_rdata <= fwd_val(bus_addr);
      end
      if (hpf_rst) hpf_cnt++;
      if (bus_we) begin
        we_cnt++;
        vectors++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3: got write %h@%h expected none", bus_wdata, bus_addr);
        end else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          if ({bus_addr, bus_wdata} !== e) begin
            fails++;
            $display("FAIL R3/R5: got %h expected %h", {bus_addr, bus_wdata}, e);
          end
        end
      end
    end
  end

  // driver: cut > 0 abandons the transfer after that many bits
  task automatic xfer(input bit rd, input bit inc, input logic [5:0] a,
                      input int n, input int cut);
    logic [7:0] cmd;
    int total;
    cmd   = {rd, inc, a};
    total = (cut > 0) ? cut : 8 * (n + 1);
    if (!rd && cut == 0)
      for (int i = 0; i < n; i++) begin
        logic [5:0] ai;
        ai = inc ? a + 6'(i) : a;
        if (!own_local(ai)) exp_q.push_back({ai, tx_buf[i]});
      end
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < total; b++) begin
      int byi, bi;
      logic bv;
      byi  = b / 8;
      bi   = 7 - (b % 8);
      bv   = (byi == 0) ? cmd[bi] : tx_buf[byi-1][bi];
      sclk   = 1'b0;
      sdi    = three_w ? ~bv : bv;
      sdio_i = three_w ? bv : ~bv;
      repeat (HALF) @(negedge clk);
      if (byi > 0) rx_buf[byi-1][bi] = sdo;
      if (b == 4)  oe_cmd = sdo_oe;
      if (b == 12) oe_dat = sdo_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    oe_idle = sdo_oe;
  endtask

  task automatic wr1(input logic [5:0] a, input logic [7:0] d);
    tx_buf[0] = d;
    xfer(1'b0, 1'b0, a, 1, 0);
  endtask

  task automatic rd1(input logic [5:0] a);
    xfer(1'b1, 1'b0, a, 1, 0);
  endtask

  initial begin
    int r0, w0, h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl1", ctrl1_o, 8'h07);
    check("R1 ctrl2", ctrl2_o, 8'h00);
    check("R1 ctrl3", ctrl3_o, 8'h08);
    check("R1 oe/pwr/boot", {sdo_oe, pwr_on, boot_busy, hpf_rst}, 4'b0000);

    // R6 identity, R2 read command, R10 4-wire enable
    r0 = re_cnt;
    rd1(6'h0F);
    check("R6 ident read", rx_buf[0], 8'h3A);
    check("R6 no bus read", re_cnt, r0);
    check("R10 oe during cmd", oe_cmd, 1'b1);
    check("R10 oe after cs", oe_idle, 1'b0);
    w0 = we_cnt;
    wr1(6'h0F, 8'h55);
    rd1(6'h0F);
    check("R6 ident unchanged", rx_buf[0], 8'h3A);
    check("R6 no bus write", we_cnt, w0);

    // R7 control bytes
    wr1(6'h20, 8'hC7);
    check("R7 ctrl1 C7", ctrl1_o, 8'hC7);
    check("R7 pwr_on", pwr_on, 1'b1);
    rd1(6'h20);
    check("R7 readback", rx_buf[0], 8'hC7);
    wr1(6'h20, 8'h27);
    check("R7 power down", {pwr_on, odr_sel}, 3'b0_10);
    wr1(6'h20, 8'h5F);
    check("R7 pwr 01 odr", {pwr_on, odr_sel}, 3'b1_01);
    wr1(6'h22, 8'hA4);
    check("R7 ctrl3", ctrl3_o, 8'hA4);

    // R3 / R5 forwarded writes
    wr1(6'h16, 8'h9C);
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
    xfer(1'b0, 1'b1, 6'h3E, 3, 0);   // R5 wraps 3E,3F,00
    tx_buf[0] = 8'h44; tx_buf[1] = 8'h55;
    xfer(1'b0, 1'b0, 6'h19, 2, 0);   // R5 fixed address

    // R4 / R5 forwarded reads
    r0 = re_cnt;
    rd1(6'h28);
    check("R4 single read", rx_buf[0], fwd_val(6'h28));
    xfer(1'b1, 1'b1, 6'h28, 3, 0);
    check("R5 burst b0", rx_buf[0], fwd_val(6'h28));
    check("R5 burst b1", rx_buf[1], fwd_val(6'h29));
    check("R5 burst b2", rx_buf[2], fwd_val(6'h2A));
    xfer(1'b1, 1'b0, 6'h2C, 2, 0);
    check("R5 fixed b1", rx_buf[1], fwd_val(6'h2C));
    check("R4 one strobe per byte", re_cnt, r0 + 6);

    // R9 dummy location, mixed local burst
    r0 = re_cnt; h0 = hpf_cnt;
    xfer(1'b1, 1'b1, 6'h21, 3, 0);
    check("R7 burst ctrl2", rx_buf[0], 8'h00);
    check("R7 burst ctrl3", rx_buf[1], 8'hA4);
    check("R9 dummy reads 0", rx_buf[2], 8'h00);
    check("R9 one hpf pulse", hpf_cnt, h0 + 1);
    check("R9 no bus read", re_cnt, r0);
    w0 = we_cnt;
    wr1(6'h23, 8'hFF);
    check("R9 write ignored", {hpf_cnt, we_cnt}, {h0 + 1, w0});

    // R8 trim reload
    wr1(6'h21, 8'h10);
    check("R8 busy starts", boot_busy, 1'b1);
    rd1(6'h21);
    check("R8 bit reads 1", rx_buf[0], 8'h10);
    repeat (BOOT + 50) @(negedge clk);
    check("R8 busy ends", boot_busy, 1'b0);
    rd1(6'h21);
    check("R8 bit cleared", rx_buf[0], 8'h00);

    // R12 abandoned transfers
    w0 = we_cnt; r0 = re_cnt;
    tx_buf[0] = 8'hEE;
    xfer(1'b0, 1'b0, 6'h16, 1, 12);
    xfer(1'b1, 1'b0, 6'h28, 1, 5);
    check("R12 no strobes", {we_cnt, re_cnt}, {w0, r0});
    rd1(6'h0F);
    check("R12 clean restart", rx_buf[0], 8'h3A);

    // R11 3-wire mode
    wr1(6'h21, 8'h02);
    check("R11 sim set", ctrl2_o, 8'h02);
    three_w = 1'b1;
    rd1(6'h0F);
    check("R11 3w read", rx_buf[0], 8'h3A);
    check("R11 oe in cmd", oe_cmd, 1'b0);
    check("R11 oe in data", oe_dat, 1'b1);
    check("R11 oe after cs", oe_idle, 1'b0);
    wr1(6'h30, 8'hA7);
    check("R11 oe on write", oe_dat, 1'b0);

    check("R3 all writes seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule